// File: doc/BRIEF.md
# Serial Auto-Baud Handshake Detector

This block watches the receive line of an 8N1 serial link whose bit rate is unknown, and works out that rate before any boot-time command traffic begins. The host sends all-zero bytes. Such a byte keeps the line low for nine bit times: the start bit and eight zero data bits. The block counts those low cycles, divides by nine, and accepts the result once two back-to-back measurements agree within about 3 percent.

With the bit period known, the block confirms it through a short exchange. It transmits a zero byte as an acknowledge and then waits for the host to send 0x55. If that byte arrives intact, it answers 0xE6, raises `done_o` and holds the divisor for the logic that handles the next protocol phase. A wrong byte, a framing error, a timeout or too many failed sync attempts each raise `err_o` and send the block back to waiting for sync bytes.

Top module: `abr_sync`

## Requirements
- R1: After reset `done_o` and `err_o` are 0, `txd_o` is 1 and `div_o` is 0.
- R2: A low run of N clock cycles gives a bit length of floor(N/9). When two consecutive lengths differ by no more than the earlier one shifted right by 5, the later one is loaded into `div_o` in clock cycles per bit.
- R3: When two consecutive lengths disagree, nothing is transmitted, and the later length becomes the reference for the next sync byte.
- R4: A low run shorter than MIN_BIT*9 cycles is ignored. It is not an attempt and it does not disturb the stored reference.
- R5: A low run that passes (MAX_BIT+1)*9 cycles is a break. It counts as an attempt and clears the stored reference.
- R6: After agreement the block transmits 0x00 on `txd_o`, 8N1 and LSB first, with each bit lasting `div_o` cycles.
- R7: If the next received byte is 0x55 with a high stop bit, the block transmits 0xE6, then sets `done_o`. `done_o` and `div_o` then hold until reset.
- R8: A received byte other than 0x55, or one with a low stop bit, makes the block transmit 0xFF, then set `err_o` and return to sync search.
- R9: When the MAX_TRIES-th attempt (default 30) since the last acceptance or error fails to agree, `err_o` is set and the attempt count restarts.
- R10: If no byte arrives within TIMEOUT_BYTES*10 bit periods (default 200) after the acknowledge ends, `err_o` is set, nothing is transmitted and sync search restarts.
- R11: `err_o` stays set until the next agreement, which clears it. It is never high together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial receive line from host, idle high |
| txd_o | output | 1 | Serial transmit line to host, idle high |
| div_o | output | BIT_W | Measured bit period in clock cycles |
| done_o | output | 1 | Handshake complete, divisor valid |
| err_o | output | 1 | Sync or handshake failure |

## Verification
The assertions assume that `rxd_i` idles high after reset and that every host bit period lies between MIN_BIT and MAX_BIT cycles. The timeout-counter bound also assumes that the host never starts a byte until the acknowledge has finished. The stimulus keeps to this: it drives the line high during reset and uses bit lengths well inside the limits. It sends its check byte only after it has fully decoded the acknowledge plus one extra bit time. Deliberate glitches and breaks are applied only while the block is searching for sync.

// File: rtl/abr_pkg.sv
package abr_pkg;
  typedef enum logic [2:0] {ST_SYNC, ST_ACK, ST_CHK, ST_RESP, ST_DONE} abr_state_e;
  localparam logic [7:0] ACK_BYTE = 8'h00;
  localparam logic [7:0] CHK_BYTE = 8'h55;
  localparam logic [7:0] OK_BYTE  = 8'hE6;
  localparam logic [7:0] BAD_BYTE = 8'hFF;
endpackage

// File: rtl/abr_measure.sv
module abr_measure #(
  parameter int BIT_W   = 16,
  parameter int MIN_BIT = 4,
  parameter int MAX_BIT = 4000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             rx_i,
  output logic             valid_o,
  output logic             brk_o,
  output logic [BIT_W-1:0] bits_o
);
  localparam logic [BIT_W-1:0] MIN_L = BIT_W'(MIN_BIT);
  localparam logic [BIT_W-1:0] MAX_L = BIT_W'(MAX_BIT);

  typedef enum logic [1:0] {M_ARM, M_IDLE, M_LOW, M_BRK} m_state_e;
  m_state_e st;
  logic [3:0] sub;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st      <= M_ARM;
      sub     <= '0;
      bits_o  <= '0;
      valid_o <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      brk_o   <= 1'b0;
      case (st)
        M_ARM:  if (rx_i) st <= M_IDLE;
        M_IDLE: if (!rx_i) begin
          st     <= M_LOW;
          sub    <= 4'd1;
          bits_o <= '0;
        end
        M_LOW: begin
          if (rx_i) begin
            st <= M_IDLE;
            if (bits_o >= MIN_L) valid_o <= 1'b1;
          end else if (sub == 4'd8) begin
            sub <= '0;
            if (bits_o == MAX_L) st <= M_BRK;
            else bits_o <= bits_o + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: if (rx_i) begin
          st    <= M_IDLE;
          brk_o <= 1'b1;
        end
      endcase
    end
  end

  a_r4_len_in_range: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (bits_o >= MIN_L && bits_o <= MAX_L));
  a_r5_break_alone: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> !valid_o);
endmodule

// File: rtl/abr_rx.sv
module abr_rx #(
  parameter int BIT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             rx_i,
  input  logic [BIT_W-1:0] div_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             ferr_o
);
  typedef enum logic [2:0] {R_ARM, R_IDLE, R_START, R_DATA, R_STOP} r_state_e;
  r_state_e st;
  logic [BIT_W-1:0] cnt;
  logic [2:0]       nbit;
  logic [7:0]       shreg;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st      <= R_ARM;
      cnt     <= '0;
      nbit    <= '0;
      shreg   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        R_ARM:  if (rx_i) st <= R_IDLE;
        R_IDLE: if (!rx_i) begin
          st  <= R_START;
          cnt <= (div_i >> 1) - 1'b1;
        end
        R_START: begin
          if (cnt == '0) begin
            if (rx_i) st <= R_IDLE;
            else begin
              st   <= R_DATA;
              cnt  <= div_i - 1'b1;
              nbit <= '0;
            end
          end else cnt <= cnt - 1'b1;
        end
        R_DATA: begin
          if (cnt == '0) begin
            shreg <= {rx_i, shreg[7:1]};
            cnt   <= div_i - 1'b1;
            nbit  <= nbit + 1'b1;
            if (nbit == 3'd7) st <= R_STOP;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          if (cnt == '0) begin
            valid_o <= 1'b1;
            data_o  <= shreg;
            ferr_o  <= !rx_i;
            st      <= R_ARM;
          end else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/abr_tx.sv
module abr_tx #(
  parameter int BIT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [BIT_W-1:0] div_i,
  output logic             txd_o,
  output logic             busy_o
);
  logic [8:0]       shreg;
  logic [BIT_W-1:0] cnt;
  logic [3:0]       nleft;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_o  <= 1'b1;
      busy_o <= 1'b0;
      shreg  <= '1;
      cnt    <= '0;
      nleft  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        txd_o  <= 1'b0;
        busy_o <= 1'b1;
        shreg  <= {1'b1, data_i};
        cnt    <= div_i - 1'b1;
        nleft  <= 4'd9;
      end
    end else if (cnt == '0) begin
      if (nleft == '0) begin
        busy_o <= 1'b0;
      end else begin
        txd_o <= shreg[0];
        shreg <= {1'b1, shreg[8:1]};
        nleft <= nleft - 1'b1;
        cnt   <= div_i - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/abr_sync.sv
module abr_sync #(
  parameter int BIT_W         = 16,
  parameter int MIN_BIT       = 4,
  parameter int MAX_BIT       = 4000,
  parameter int MAX_TRIES     = 30,
  parameter int TIMEOUT_BYTES = 20,
  parameter int TOL_SHIFT     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd_i,
  output logic             txd_o,
  output logic [BIT_W-1:0] div_o,
  output logic             done_o,
  output logic             err_o
);
  import abr_pkg::*;

  localparam int TO_BITS = TIMEOUT_BYTES * 10;
  localparam int TO_W    = BIT_W + $clog2(TO_BITS + 1);
  localparam int TR_W    = $clog2(MAX_TRIES + 1);

  abr_state_e st;
  logic rx_m, rx_s;
  logic m_valid, m_brk;
  logic [BIT_W-1:0] m_bits, prev, diff;
  logic have_prev, agree, meas_evt, last_try;
  logic [TR_W-1:0] tries;
  logic r_valid, r_ferr;
  logic [7:0] r_data;
  logic tx_go, tx_busy, tx_busy_q, tx_fin, resp_ok;
  logic [7:0] tx_byte;
  logic [TO_W-1:0] to_cnt, to_lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      tx_busy_q <= 1'b0;
    end else begin
      rx_m <= rxd_i;
      rx_s <= rx_m;
      tx_busy_q <= tx_busy;
    end
  end

  abr_measure #(.BIT_W(BIT_W), .MIN_BIT(MIN_BIT), .MAX_BIT(MAX_BIT)) u_meas (
    .clk(clk), .rst(rst), .en_i(st == ST_SYNC), .rx_i(rx_s),
    .valid_o(m_valid), .brk_o(m_brk), .bits_o(m_bits));

  abr_rx #(.BIT_W(BIT_W)) u_rx (
    .clk(clk), .rst(rst), .en_i(st == ST_CHK), .rx_i(rx_s), .div_i(div_o),
    .valid_o(r_valid), .data_o(r_data), .ferr_o(r_ferr));

  abr_tx #(.BIT_W(BIT_W)) u_tx (
    .clk(clk), .rst(rst), .start_i(tx_go), .data_i(tx_byte), .div_i(div_o),
    .txd_o(txd_o), .busy_o(tx_busy));

  assign tx_fin   = tx_busy_q && !tx_busy;
  assign diff     = (m_bits > prev) ? (m_bits - prev) : (prev - m_bits);
  assign agree    = have_prev && (diff <= (prev >> TOL_SHIFT));
  assign meas_evt = m_brk || (m_valid && !agree);
  assign last_try = (tries == TR_W'(MAX_TRIES - 1));
  assign to_lim   = TO_W'(div_o) * TO_W'(TO_BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_SYNC;
      prev <= '0;
      have_prev <= 1'b0;
      tries <= '0;
      div_o <= '0;
      done_o <= 1'b0;
      err_o <= 1'b0;
      tx_go <= 1'b0;
      tx_byte <= '0;
      to_cnt <= '0;
      resp_ok <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      case (st)
        ST_SYNC: begin
          if (m_valid && agree) begin
            div_o <= m_bits;
            err_o <= 1'b0;
            tries <= '0;
            have_prev <= 1'b0;
            tx_byte <= ACK_BYTE;
            tx_go <= 1'b1;
            st <= ST_ACK;
          end else if (meas_evt) begin
            prev <= m_bits;
            have_prev <= m_valid && !last_try;
            if (last_try) begin
              tries <= '0;
              err_o <= 1'b1;
            end else begin
              tries <= tries + 1'b1;
            end
          end
        end
        ST_ACK: if (tx_fin) begin
          st <= ST_CHK;
          to_cnt <= '0;
        end
        ST_CHK: begin
          if (r_valid) begin
            resp_ok <= !r_ferr && (r_data == CHK_BYTE);
            tx_byte <= (!r_ferr && (r_data == CHK_BYTE)) ? OK_BYTE : BAD_BYTE;
            tx_go <= 1'b1;
            st <= ST_RESP;
          end else if (to_cnt == to_lim - 1'b1) begin
            err_o <= 1'b1;
            st <= ST_SYNC;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_RESP: if (tx_fin) begin
          if (resp_ok) begin
            done_o <= 1'b1;
            st <= ST_DONE;
          end else begin
            err_o <= 1'b1;
            st <= ST_SYNC;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && $stable(div_o)));
  a_r11_never_both: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
  a_r6_quiet_in_sync: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SYNC) |-> txd_o);
  a_r9_tries_bound: assert property (@(posedge clk) disable iff (rst)
    tries < TR_W'(MAX_TRIES));
  a_r10_timer_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHK) |-> (to_cnt < to_lim));
  a_r2_div_range: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (div_o >= BIT_W'(MIN_BIT) && div_o <= BIT_W'(MAX_BIT)));
endmodule

// File: tb/abr_sync_bench.sv
module abr_sync_bench;
  localparam int BIT_W = 16;
  localparam int MAXB  = 64;
  localparam int NV    = 5;
  localparam int V_BL [NV] = '{16, 16, 12, 23, 10};
  localparam logic [7:0] V_REPLY [NV] = '{8'h55, 8'h54, 8'h55, 8'h55, 8'hAA};
  localparam logic       V_STOP  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [7:0] V_EXP   [NV] = '{8'hE6, 8'hFF, 8'hFF, 8'hE6, 8'hFF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic txd, done, err;
  logic [BIT_W-1:0] div;
  int checks = 0;
  int errors = 0;
  int mon_bl = 16;
  int tx_n = 0;
  logic [7:0] tx_log [8];

  always #4 clk = ~clk;

  abr_sync #(.BIT_W(BIT_W), .MAX_BIT(MAXB)) u_abr_sync (
    .clk(clk), .rst(rst), .rxd_i(rxd), .txd_o(txd),
    .div_o(div), .done_o(done), .err_o(err));

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int bl, input logic stop);
    rxd = 1'b0; idle(bl);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; idle(bl); end
    rxd = stop; idle(bl);
    rxd = 1'b1; idle(2 * bl);
  endtask

  task automatic low_pulse(input int n);
    rxd = 1'b0; idle(n);
    rxd = 1'b1; idle(40);
  endtask

  task automatic wait_tx(input int n);
    for (int k = 0; k < 6000 && tx_n < n; k++) idle(1);
  endtask

  task automatic do_reset;
    rst = 1'b1; rxd = 1'b1; idle(5);
    rst = 1'b0; idle(5);
    tx_n = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && txd == 1'b0) begin
        logic [7:0] b;
        idle(mon_bl / 2);
        for (int i = 0; i < 8; i++) begin idle(mon_bl); b[i] = txd; end
        idle(2 * mon_bl);
        if (tx_n < 8) tx_log[tx_n] = b;
        tx_n++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset;
    check(done == 1'b0, "R1 done", done, 0);
    check(err == 1'b0, "R1 err", err, 0);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(div == '0, "R1 div", div, 0);

    // table walk: R2 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int bl;
      bl = V_BL[v];
      do_reset;
      mon_bl = bl;
      send_byte(8'h00, bl, 1'b1);
      send_byte(8'h00, bl, 1'b1);
      wait_tx(1);
      check(tx_n == 1 && tx_log[0] == 8'h00, "R6 ack byte", tx_log[0], 0);
      check(div == BIT_W'(bl), "R2 divisor", div, bl);
      send_byte(V_REPLY[v], bl, V_STOP[v]);
      wait_tx(2);
      idle(3 * bl);
      check(tx_log[1] == V_EXP[v], "R7/R8 response", tx_log[1], V_EXP[v]);
      check(done == (V_EXP[v] == 8'hE6), "R7 done", done, V_EXP[v] == 8'hE6);
      check(err == (V_EXP[v] == 8'hFF), "R8 err", err, V_EXP[v] == 8'hFF);
    end

    // R2 tolerance: 40 then 41 agree, later one loaded
    do_reset; mon_bl = 41;
    send_byte(8'h00, 40, 1'b1);
    send_byte(8'h00, 41, 1'b1);
    wait_tx(1);
    check(tx_n == 1, "R2 tolerance ack", tx_n, 1);
    check(div == 16'd41, "R2 tolerance div", div, 41);

    // R3 disagreement then agreement
    do_reset; mon_bl = 20;
    send_byte(8'h00, 16, 1'b1);
    send_byte(8'h00, 20, 1'b1);
    idle(100);
    check(tx_n == 0, "R3 no ack on mismatch", tx_n, 0);
    send_byte(8'h00, 20, 1'b1);
    wait_tx(1);
    check(tx_n == 1 && div == 16'd20, "R3 later reference", div, 20);

    // R4 glitch ignored
    do_reset; mon_bl = 16;
    send_byte(8'h00, 16, 1'b1);
    low_pulse(10);
    send_byte(8'h00, 16, 1'b1);
    wait_tx(1);
    check(tx_n == 1 && div == 16'd16, "R4 glitch ignored", tx_n, 1);

    // R5 break clears reference
    do_reset; mon_bl = 16;
    send_byte(8'h00, 16, 1'b1);
    low_pulse(700);
    send_byte(8'h00, 16, 1'b1);
    idle(100);
    check(tx_n == 0, "R5 break cleared reference", tx_n, 0);
    send_byte(8'h00, 16, 1'b1);
    wait_tx(1);
    check(tx_n == 1, "R5 recovery after break", tx_n, 1);

    // R10 timeout, R11 clear on next agreement
    do_reset; mon_bl = 16;
    send_byte(8'h00, 16, 1'b1);
    send_byte(8'h00, 16, 1'b1);
    wait_tx(1);
    idle(3000);
    check(err == 1'b0, "R10 no early timeout", err, 0);
    idle(300);
    check(err == 1'b1, "R10 timeout err", err, 1);
    check(tx_n == 1, "R10 nothing sent", tx_n, 1);
    send_byte(8'h00, 16, 1'b1);
    send_byte(8'h00, 16, 1'b1);
    wait_tx(2);
    check(err == 1'b0, "R11 err cleared", err, 0);
    send_byte(8'h55, 16, 1'b1);
    wait_tx(3);
    idle(48);
    check(done == 1'b1 && tx_log[2] == 8'hE6, "R11 handshake after recovery", tx_log[2], 8'hE6);

    // R9 thirty failed attempts
    do_reset; mon_bl = 16;
    for (int i = 0; i < 29; i++) send_byte(8'h00, (i % 2 == 0) ? 16 : 24, 1'b1);
    check(err == 1'b0 && tx_n == 0, "R9 no error before limit", err, 0);
    send_byte(8'h00, 24, 1'b1);
    check(err == 1'b1 && tx_n == 0, "R9 error at limit", err, 1);
    send_byte(8'h00, 16, 1'b1);
    send_byte(8'h00, 16, 1'b1);
    wait_tx(1);
    check(tx_n == 1 && err == 1'b0, "R9 R11 resync", err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule